// File: doc/BRIEF.md
# NAND Page Operation Sequencer

This block runs complete page-read, page-program and block-erase sequences against a 16-bit wide NAND flash device. The device bus is modelled as four strobes (command, address, write data, read data), a 16-bit output word and a 16-bit input word. Each strobe lasts one clock cycle, and at most one strobe is active in any cycle. The host supplies an operation code, a block index and a page index, and pulses start. The block then builds the device byte address from the two indices and emits the command and address cycles in order. It polls the device status until the device reports ready, and moves page data through a host-side word stream with one word per cycle.

The byte address is `(block << BLK_SHIFT) + (page << PG_SHIFT)`. Read and program split it into five address cycles of 8, 3, 8, 8 and 1 bits. Erase discards the 11 column bits and sends three 8-bit row cycles. Each status poll is a read-status command cycle followed by one read-data cycle. Polling gives up after `RETRY_MAX` polls and reports a timeout. The operation ends with a one-cycle done pulse, and the timeout and fail flags hold their values until the next accepted start.

Top module: `nand_seq`

## Requirements
- R1: For read and program, the five address cycles carry, in order, the low byte of the output word equal to A[7:0], A[10:8], A[18:11], A[26:19] and A[27]. Here A = (block << BLK_SHIFT) + (page << PG_SHIFT), and unused upper bits of each byte are zero.
- R2: Erase sends command 0x60, then three address cycles carrying bits [7:0], [15:8] and [23:16] of A >> 11, then command 0x D0, then status polling.
- R3: Read sends command 0x00, the five address cycles, command 0x30 and status polling. After ready, it sends command 0x00 again and then performs MAIN_WORDS + SPARE_WORDS read-data cycles. Each of these cycles raises rd_valid_o with rd_word_o equal to the device word.
- R4: Program sends command 0x80 and the five address cycles. It then performs MAIN_WORDS + SPARE_WORDS write-data cycles, each driving wr_word_i onto the bus with wr_take_o high. It then sends command 0x10 and status polling.
- R5: A status poll is command 0x70 followed by one read-data cycle, and status bit 6 means ready. After RETRY_MAX polls with no ready, the operation ends with timeout_o = 1 and no further cycles. Ready on the last permitted poll is a success.
- R6: After program or erase, fail_o equals status bit 0 of the ready poll. A read never sets fail_o, and a timeout leaves fail_o at 0.
- R7: done_o is high for exactly one cycle per operation. A start raised while busy_o is high, including the done cycle, has no effect. A start with operation code 3 is ignored. The codes are 0 read, 1 program, 2 erase.
- R8: At most one of the four bus strobes is high in any cycle. busy_o is high from the cycle after an accepted start through the done cycle.
- R9: In reset, busy_o, done_o and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| op_i | input | 2 | Operation: 0 read, 1 program, 2 erase, 3 none |
| blk_i | input | BLK_W | Block index |
| pg_i | input | PG_W | Page index |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last operation ran out of status polls |
| fail_o | output | 1 | Last program or erase reported failure |
| cmd_strb_o | output | 1 | Command cycle |
| addr_strb_o | output | 1 | Address cycle |
| wdata_strb_o | output | 1 | Write-data cycle |
| rdata_strb_o | output | 1 | Read-data cycle (status or page data) |
| bus_dout_o | output | 16 | Command, address or write word |
| bus_din_i | input | 16 | Word returned by the device |
| wr_word_i | input | 16 | Host word to program |
| wr_take_o | output | 1 | wr_word_i consumed this cycle |
| rd_valid_o | output | 1 | rd_word_o holds a page word |
| rd_word_o | output | 16 | Page word to host |

## Verification
Two events can land in the same status-read cycle: the poll budget runs out, and the device reports ready. The bench provokes this by holding the modelled device busy for exactly RETRY_MAX-1 polls, so ready appears on the final permitted poll. It expects a normal completion with the full data phase and no timeout. Holding the device busy one poll longer must instead yield a timeout with nothing after the last poll. A second collision is a start pulse arriving in the done cycle; the bench injects one there and expects the block to stay idle afterwards.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_NONE  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_PCMD, S_PRD, S_RECMD, S_DATA, S_DONE
  } st_e;

  localparam int        AW        = 40;
  localparam logic [7:0] C_RD_A   = 8'h00;
  localparam logic [7:0] C_RD_B   = 8'h30;
  localparam logic [7:0] C_PG_A   = 8'h80;
  localparam logic [7:0] C_PG_B   = 8'h10;
  localparam logic [7:0] C_ER_A   = 8'h60;
  localparam logic [7:0] C_ER_B   = 8'hD0;
  localparam logic [7:0] C_STAT   = 8'h70;
  localparam int        RDY_BIT   = 6;
  localparam int        FAIL_BIT  = 0;

  // device byte address from block and page indices
  function automatic logic [AW-1:0] byte_addr(logic [AW-1:0] blk, logic [AW-1:0] pg,
                                               int bsh, int psh);
    return (blk << bsh) + (pg << psh);
  endfunction

  // one address-cycle byte; erase uses row-only cycles
  function automatic logic [7:0] addr_cycle(logic [AW-1:0] a, logic [2:0] idx, logic erase);
    logic [AW-1:0] row;
    row = a >> 11;
    if (erase) begin
      case (idx)
        3'd0:    return row[7:0];
        3'd1:    return row[15:8];
        default: return row[23:16];
      endcase
    end else begin
      case (idx)
        3'd0:    return a[7:0];
        3'd1:    return {5'b0, a[10:8]};
        3'd2:    return a[18:11];
        3'd3:    return a[26:19];
        default: return {7'b0, a[27]};
      endcase
    end
  endfunction

  function automatic logic [7:0] first_cmd(op_e op);
    case (op)
      OP_PROG:  return C_PG_A;
      OP_ERASE: return C_ER_A;
      default:  return C_RD_A;
    endcase
  endfunction

  function automatic logic [7:0] second_cmd(op_e op);
    case (op)
      OP_PROG:  return C_PG_B;
      OP_ERASE: return C_ER_B;
      default:  return C_RD_B;
    endcase
  endfunction

endpackage

// File: rtl/nand_step_ctr.sv
module nand_step_ctr #(
  parameter int LIMIT = 5,
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [CW-1:0] cnt_o,
  output logic          last_o
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear_i) cnt <= '0;
    else if (step_i)  cnt <= cnt + 1'b1;
  end

  assign cnt_o  = cnt;
  assign last_o = (cnt == CW'(LIMIT - 1));

  // R5
  ctr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/nand_addr_fmt.sv
module nand_addr_fmt
  import nand_seq_pkg::*;
#(
  parameter int BLK_W     = 11,
  parameter int PG_W      = 6,
  parameter int BLK_SHIFT = 17,
  parameter int PG_SHIFT  = 11
) (
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  pg_i,
  input  logic [2:0]       idx_i,
  input  logic             erase_i,
  output logic [7:0]       byte_o,
  output logic             last_o
);

  logic [AW-1:0] dev_addr;

  assign dev_addr = byte_addr(AW'(blk_i), AW'(pg_i), BLK_SHIFT, PG_SHIFT);
  assign byte_o   = addr_cycle(dev_addr, idx_i, erase_i);
  assign last_o   = erase_i ? (idx_i == 3'd2) : (idx_i == 3'd4);

endmodule

// File: rtl/nand_seq.sv
module nand_seq
  import nand_seq_pkg::*;
#(
  parameter int BLK_W       = 11,
  parameter int PG_W        = 6,
  parameter int BLK_SHIFT   = 17,
  parameter int PG_SHIFT    = 11,
  parameter int MAIN_WORDS  = 1024,
  parameter int SPARE_WORDS = 32,
  parameter int RETRY_MAX   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic [PG_W-1:0]  pg_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             timeout_o,
  output logic             fail_o,
  output logic             cmd_strb_o,
  output logic             addr_strb_o,
  output logic             wdata_strb_o,
  output logic             rdata_strb_o,
  output logic [15:0]      bus_dout_o,
  input  logic [15:0]      bus_din_i,
  input  logic [15:0]      wr_word_i,
  output logic             wr_take_o,
  output logic             rd_valid_o,
  output logic [15:0]      rd_word_o
);

  localparam int TOTAL_WORDS = MAIN_WORDS + SPARE_WORDS;
  localparam int ADDR_CYC    = 5;
  localparam int ACW = $clog2(ADDR_CYC);
  localparam int PCW = (RETRY_MAX > 1)   ? $clog2(RETRY_MAX)   : 1;
  localparam int WCW = (TOTAL_WORDS > 1) ? $clog2(TOTAL_WORDS) : 1;

  st_e              st, st_nx;
  op_e              op_q;
  logic [BLK_W-1:0] blk_q;
  logic [PG_W-1:0]  pg_q;
  logic             tmo_q, fail_q;

  // named internal events
  logic acc_evt, poll_rdy, poll_miss, poll_expire;
  logic addr_last, word_last, poll_last;
  logic [ACW-1:0] addr_idx;
  logic [PCW-1:0] poll_cnt;
  logic [WCW-1:0] word_cnt;
  logic [7:0]     addr_byte;
  logic           in_addr, in_data;

  assign acc_evt     = (st == S_IDLE) && start_i && (op_e'(op_i) != OP_NONE);
  assign poll_rdy    = (st == S_PRD) &&  bus_din_i[RDY_BIT];
  assign poll_miss   = (st == S_PRD) && !bus_din_i[RDY_BIT];
  assign poll_expire = poll_miss && poll_last;
  assign in_addr     = (st == S_ADDR);
  assign in_data     = (st == S_DATA);

  nand_step_ctr #(.LIMIT(ADDR_CYC)) u_addr_ctr (
    .clk(clk), .rst_n(rst_n),
    .clear_i(acc_evt || (in_addr && addr_last)),
    .step_i(in_addr), .cnt_o(addr_idx), .last_o()
  );

  nand_step_ctr #(.LIMIT(RETRY_MAX)) u_poll_ctr (
    .clk(clk), .rst_n(rst_n),
    .clear_i(acc_evt),
    .step_i(poll_miss && !poll_last), .cnt_o(poll_cnt), .last_o(poll_last)
  );

  nand_step_ctr #(.LIMIT(TOTAL_WORDS)) u_word_ctr (
    .clk(clk), .rst_n(rst_n),
    .clear_i(acc_evt || (in_data && word_last)),
    .step_i(in_data), .cnt_o(word_cnt), .last_o(word_last)
  );

  nand_addr_fmt #(
    .BLK_W(BLK_W), .PG_W(PG_W), .BLK_SHIFT(BLK_SHIFT), .PG_SHIFT(PG_SHIFT)
  ) u_addr_fmt (
    .blk_i(blk_q), .pg_i(pg_q), .idx_i(addr_idx),
    .erase_i(op_q == OP_ERASE), .byte_o(addr_byte), .last_o(addr_last)
  );

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (acc_evt) st_nx = S_CMD1;
      S_CMD1:  st_nx = S_ADDR;
      S_ADDR:  if (addr_last) st_nx = (op_q == OP_PROG) ? S_DATA : S_CMD2;
      S_CMD2:  st_nx = S_PCMD;
      S_PCMD:  st_nx = S_PRD;
      S_PRD: begin
        if (poll_rdy)         st_nx = (op_q == OP_READ) ? S_RECMD : S_DONE;
        else if (poll_last)   st_nx = S_DONE;
        else                  st_nx = S_PCMD;
      end
      S_RECMD: st_nx = S_DATA;
      S_DATA:  if (word_last) st_nx = (op_q == OP_PROG) ? S_CMD2 : S_DONE;
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op_q   <= OP_READ;
      blk_q  <= '0;
      pg_q   <= '0;
      tmo_q  <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st <= st_nx;
      if (acc_evt) begin
        op_q   <= op_e'(op_i);
        blk_q  <= blk_i;
        pg_q   <= pg_i;
        tmo_q  <= 1'b0;
        fail_q <= 1'b0;
      end
      if (poll_expire) tmo_q <= 1'b1;
      if (poll_rdy && op_q != OP_READ) fail_q <= bus_din_i[FAIL_BIT];
    end
  end

  assign cmd_strb_o   = (st == S_CMD1) || (st == S_CMD2) || (st == S_PCMD) || (st == S_RECMD);
  assign addr_strb_o  = in_addr;
  assign wdata_strb_o = in_data && (op_q == OP_PROG);
  assign rdata_strb_o = (st == S_PRD) || (in_data && op_q == OP_READ);

  always_comb begin
    case (st)
      S_CMD1:  bus_dout_o = {8'h00, first_cmd(op_q)};
      S_CMD2:  bus_dout_o = {8'h00, second_cmd(op_q)};
      S_PCMD:  bus_dout_o = {8'h00, C_STAT};
      S_RECMD: bus_dout_o = {8'h00, C_RD_A};
      S_ADDR:  bus_dout_o = {8'h00, addr_byte};
      S_DATA:  bus_dout_o = (op_q == OP_PROG) ? wr_word_i : 16'h0000;
      default: bus_dout_o = 16'h0000;
    endcase
  end

  assign wr_take_o  = wdata_strb_o;
  assign rd_valid_o = in_data && (op_q == OP_READ);
  assign rd_word_o  = bus_din_i;
  assign busy_o     = (st != S_IDLE);
  assign done_o     = (st == S_DONE);
  assign timeout_o  = tmo_q;
  assign fail_o     = fail_q;

  // R8
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_strb_o, addr_strb_o, wdata_strb_o, rdata_strb_o}));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  // R7
  start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> ($stable(op_q) && $stable(blk_q) && $stable(pg_q)));

  // R6
  read_never_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && op_q == OP_READ) |-> !fail_o);

  // R5
  ready_not_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_rdy |=> !timeout_o);

  // R5
  expire_at_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_expire |-> (poll_cnt == PCW'(RETRY_MAX - 1)));

  // R2
  erase_three_cycles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_strb_o && op_q == OP_ERASE) |-> (addr_idx < ACW'(3)));

  // R3
  data_after_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid_o) |-> ($past(cmd_strb_o) && $past(bus_dout_o) == 16'h0000));

  // R4
  take_only_program_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take_o |-> (op_q == OP_PROG && word_cnt < WCW'(TOTAL_WORDS)));

endmodule

// File: tb/tb_nand_seq.sv
`timescale 1ns/1ps
module tb_nand_seq;

  localparam int BLK_W = 11;
  localparam int PG_W  = 6;
  localparam int MW    = 4;
  localparam int SW    = 2;
  localparam int RTRY  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic start_t = 1'b0, start_poke = 1'b0;
  logic start_i;
  logic [1:0] op_t = 2'd0;
  logic [BLK_W-1:0] blk_t = '0;
  logic [PG_W-1:0]  pg_t = '0;
  logic busy, done, tmo, fail, cs, as, ws, rs, wr_take, rd_valid;
  logic [15:0] dout, din, wr_word, rd_word;

  assign start_i = start_t | start_poke;

  nand_seq #(.BLK_W(BLK_W), .PG_W(PG_W), .BLK_SHIFT(17), .PG_SHIFT(11),
             .MAIN_WORDS(MW), .SPARE_WORDS(SW), .RETRY_MAX(RTRY)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_t), .blk_i(blk_t), .pg_i(pg_t),
    .busy_o(busy), .done_o(done), .timeout_o(tmo), .fail_o(fail),
    .cmd_strb_o(cs), .addr_strb_o(as), .wdata_strb_o(ws), .rdata_strb_o(rs),
    .bus_dout_o(dout), .bus_din_i(din), .wr_word_i(wr_word), .wr_take_o(wr_take),
    .rd_valid_o(rd_valid), .rd_word_o(rd_word));

  // device and host model
  logic [7:0] last_cmd = 8'hFF;
  int poll_n = 0, rd_n = 0, take_n = 0, busy_polls = 0;
  logic fail_bit = 1'b0;

  function automatic logic [15:0] dword(int i, logic [BLK_W-1:0] b);
    return 16'hC300 ^ 16'(i * 16'h0111) ^ {5'b0, b};
  endfunction
  function automatic logic [15:0] stat_word(int i, int bp, logic fb);
    return {8'h00, 1'b0, (i >= bp), 5'b0, fb};
  endfunction

  assign din     = (last_cmd == 8'h70) ? stat_word(poll_n, busy_polls, fail_bit) : dword(rd_n, blk_t);
  assign wr_word = 16'h3A00 + 16'(take_n);

  always @(posedge clk) begin
    if (start_i && !busy) begin
      poll_n <= 0; rd_n <= 0; take_n <= 0;
    end else begin
      if (rs && last_cmd == 8'h70) poll_n <= poll_n + 1;
      else if (rs)                 rd_n <= rd_n + 1;
      if (wr_take) take_n <= take_n + 1;
    end
    if (cs) last_cmd <= dout[7:0];
  end

  // monitor
  int mon_k [0:63];
  logic [15:0] mon_v [0:63];
  int mon_n = 0, done_cnt = 0, rdv_n = 0, take_seen = 0;
  bit done_seen = 0, poke_en = 0;

  always @(negedge clk) begin
    start_poke <= 1'b0;
    if (rst_n) begin
      if (mon_n < 64) begin
        if (cs)      begin mon_k[mon_n] = 1; mon_v[mon_n] = dout; mon_n++; end
        else if (as) begin mon_k[mon_n] = 2; mon_v[mon_n] = dout; mon_n++; end
        else if (ws) begin mon_k[mon_n] = 3; mon_v[mon_n] = dout; mon_n++; end
        else if (rs) begin mon_k[mon_n] = 4; mon_v[mon_n] = din;  mon_n++; end
      end
      if (rd_valid) begin
        rdv_n++;
        if (rd_word != din) rdv_n += 100;
      end
      if (wr_take) take_seen++;
      if (done) begin
        done_cnt++; done_seen = 1;
        if (poke_en) start_poke <= 1'b1;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int exp_k [0:63];
  logic [15:0] exp_v [0:63];
  int exp_n = 0;
  task automatic push(input int k, input logic [15:0] v);
    exp_k[exp_n] = k; exp_v[exp_n] = v; exp_n++;
  endtask

  task automatic run_op(input int op, input logic [BLK_W-1:0] b, input logic [PG_W-1:0] p,
                        input int bp, input logic fb, input bit poke);
    logic [63:0] a, r;
    int npoll, cyc;
    bit to_exp, fail_exp;
    string tag;
    tag = (op == 0) ? "R3" : (op == 1) ? "R4" : "R2";
    a = (64'(b) << 17) + (64'(p) << 11);
    r = a >> 11;
    to_exp = (bp >= RTRY);
    npoll  = to_exp ? RTRY : bp + 1;
    fail_exp = !to_exp && (op != 0) && fb;
    exp_n = 0;
    push(1, (op == 0) ? 16'h00 : (op == 1) ? 16'h80 : 16'h60);
    if (op == 2) begin
      push(2, {8'h0, r[7:0]}); push(2, {8'h0, r[15:8]}); push(2, {8'h0, r[23:16]});
      push(1, 16'hD0);
    end else begin
      push(2, {8'h0, a[7:0]}); push(2, {13'h0, a[10:8]}); push(2, {8'h0, a[18:11]});
      push(2, {8'h0, a[26:19]}); push(2, {15'h0, a[27]});
      if (op == 0) push(1, 16'h30);
      else begin
        for (int i = 0; i < MW + SW; i++) push(3, 16'h3A00 + 16'(i));
        push(1, 16'h10);
      end
    end
    for (int i = 0; i < npoll; i++) begin push(1, 16'h70); push(4, stat_word(i, bp, fb)); end
    if (op == 0 && !to_exp) begin
      push(1, 16'h00);
      for (int i = 0; i < MW + SW; i++) push(4, dword(i, b));
    end

    @(posedge clk); #1;
    busy_polls = bp; fail_bit = fb; poke_en = poke;
    mon_n = 0; done_cnt = 0; rdv_n = 0; take_seen = 0; done_seen = 0;
    op_t = 2'(op); blk_t = b; pg_t = p; start_t = 1'b1;
    @(posedge clk); #1;
    start_t = 1'b0;
    chk(busy == 1'b1, "R8", "busy after start", 64'(busy), 1);
    if (poke) begin
      @(posedge clk); #1;
      start_t = 1'b1; op_t = 2'((op + 1) % 3);
      @(posedge clk); #1;
      start_t = 1'b0; op_t = 2'(op);
    end
    cyc = 0;
    while (!done_seen && cyc < 400) begin @(posedge clk); #1; cyc++; end
    chk(done_seen, tag, "done seen", 64'(done_seen), 1);
    chk(busy == 1'b0, "R7", "idle after done", 64'(busy), 0);
    chk(tmo == to_exp, "R5", "timeout flag", 64'(tmo), 64'(to_exp));
    chk(fail == fail_exp, "R6", "fail flag", 64'(fail), 64'(fail_exp));
    @(posedge clk); #1;
    chk(busy == 1'b0 && done_cnt == 1, "R7", "single done, poke ignored", 64'(done_cnt), 1);
    chk(mon_n == exp_n, tag, "cycle count", 64'(mon_n), 64'(exp_n));
    for (int i = 0; i < exp_n && i < mon_n; i++) begin
      if (mon_k[i] != exp_k[i] || mon_v[i] !== exp_v[i]) begin
        string t2;
        t2 = (exp_k[i] == 2) ? ((op == 2) ? "R2" : "R1") :
             ((exp_v[i] == 16'h70 && exp_k[i] == 1) || (i > 0 && exp_k[i-1] == 1 && exp_v[i-1] == 16'h70)) ? "R5" : tag;
        chk(1'b0, t2, $sformatf("event %0d kind %0d", i, exp_k[i]),
            {mon_k[i][15:0], 32'h0, mon_v[i]}, {exp_k[i][15:0], 32'h0, exp_v[i]});
        break;
      end
    end
    chk(1'b1, tag, "sequence compared", 0, 0);
    chk(rdv_n == ((op == 0 && !to_exp) ? MW + SW : 0), "R3", "rd_valid count",
        64'(rdv_n), 64'((op == 0 && !to_exp) ? MW + SW : 0));
    chk(take_seen == ((op == 1) ? MW + SW : 0), "R4", "wr_take count",
        64'(take_seen), 64'((op == 1) ? MW + SW : 0));
  endtask

  initial begin
    automatic int bl [6] = '{0, 1, 5, 1023, 1024, 2047};
    automatic int pl [4] = '{0, 1, 37, 63};
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !done && !cs && !as && !ws && !rs, "R9", "reset outputs",
        {busy, done, cs, as, ws, rs}, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk(!busy && !done, "R9", "idle after reset", {busy, done}, 0);

    for (int bi = 0; bi < 6; bi++)
      for (int pi = 0; pi < 4; pi++)
        for (int op = 0; op < 3; op++)
          run_op(op, BLK_W'(bl[bi]), PG_W'(pl[pi]), (bi + pi + op) % 3, 1'((bi + pi) % 2), pi == 2);

    for (int op = 0; op < 3; op++) begin
      run_op(op, 11'd777, 6'd21, RTRY - 1, 1'b0, 1'b0);  // R5 ready on final poll
      run_op(op, 11'd777, 6'd21, RTRY, 1'b1, 1'b0);      // R5 timeout
      run_op(op, 11'd3, 6'd62, 0, 1'b1, 1'b1);           // R6 fail bit
    end

    // R7 operation code 3 ignored
    @(posedge clk); #1;
    mon_n = 0;
    op_t = 2'd3; start_t = 1'b1;
    @(posedge clk); #1;
    start_t = 1'b0; op_t = 2'd0;
    chk(busy == 1'b0, "R7", "code 3 not accepted", 64'(busy), 0);
    repeat (3) @(posedge clk);
    #1;
    chk(busy == 1'b0 && mon_n == 0, "R7", "code 3 no bus cycles", 64'(mon_n), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule